// File: doc/BRIEF.md
# Indexed Clock-Channel Configuration Register

This block is the control register for a bank of derived clock channels. Every channel is reached through one 32-bit word at a single address. Each channel holds three settings: a source select, a divider code and an enable. The block drives these settings out as per-channel configuration buses, which go to the clock mux and divider logic that sits outside the block.

A write to the word names a channel in its low four bits. If the write's command bit is clear, it changes no channel's settings. It only moves the readback pointer, so that later reads return that channel's fields. If the command bit is set, the write stores its field values into the named channel and also moves the pointer to that channel.

After a stored change, the channel's ready flag goes low for a fixed settling window and then rises again. Channel 0 has its own ready output. All the other channels share one combined ready output.

Top module: `clkcfg_regbank`

## Requirements
- R1: After reset, every channel has source 0 and divider code 0. Every channel has enable 0 except channel 0, which has enable 1. All ready flags are 1. A read at offset 0x30 returns 0x1000_0000, meaning channel 0 is selected.
- R2: A write at offset 0x30 with bit 7 set stores three fields into the channel named in bits 3:0, for IDs 0 to 4. The fields are source select (bits 20:16), divider code (bits 10:8) and enable (bit 28). The stored values appear on that channel's outputs in the cycle after the write edge. No other channel changes.
- R3: A write at offset 0x30 with bit 7 clear and ID 0 to 4 changes no channel output. It only selects that channel for readback.
- R4: A read at offset 0x30 returns the selected channel's fields. The ID is in bits 3:0, the source in bits 20:16, the divider in bits 10:8 and the enable in bit 28. Bit 7 and all other bits read 0. A read at any other address returns 0.
- R5: A write at offset 0x30 whose ID is 5 or more has no effect, whatever bit 7 holds. No channel output changes, and the readback selection is unchanged.
- R6: A write to any address other than 0x30 changes no output and does not change the readback selection.
- R7: A stored change drives that channel's ready flag low for exactly SETTLE_CYC cycles (default 4) after the write edge. The ready flags of the other channels are unaffected.
- R8: `rdy_main` follows channel 0's ready flag. `rdy_aux` is 1 only when channels 1 to 4 are all ready.
- R9: A write with bit 7 set and a valid ID also selects that channel for readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| ch_src | output | 25 | Source select per channel, 5 bits each, channel 0 lowest |
| ch_div | output | 15 | Divider code per channel, 3 bits each |
| ch_en | output | 5 | Enable per channel |
| ch_ready | output | 5 | Ready flag per channel |
| rdy_main | output | 1 | Ready of channel 0 |
| rdy_aux | output | 1 | Combined ready of channels 1 to 4 |

## Verification
A wrong readback pointer shows as soon as the next read: that read returns the wrong ID in bits 3:0, or another channel's fields. A corrupted channel register shows on that channel's output bus in the cycle after the faulty write. A settle counter that is loaded wrong, or that counts down wrong, changes how long ready stays low, so it is caught within SETTLE_CYC+1 cycles of a stored change. Sweeping every ID from 0 to 15, with both command-bit values, exposes any leak from an ignored write into a channel or into the pointer.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int ID_W   = 4;
    localparam int SRC_W  = 5;
    localparam int DIV_W  = 3;
    localparam int WORD_W = 32;

    localparam int ID_LSB  = 0;
    localparam int CMD_BIT = 7;
    localparam int DIV_LSB = 8;
    localparam int SRC_LSB = 16;
    localparam int EN_BIT  = 28;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } ch_cfg_t;

    function automatic ch_cfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        ch_cfg_t c;
        c.en  = w[EN_BIT];
        c.src = w[SRC_LSB +: SRC_W];
        c.div = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [ID_W-1:0] id,
                                                    input ch_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ID_LSB +: ID_W]   = id;
        w[DIV_LSB +: DIV_W] = c.div;
        w[SRC_LSB +: SRC_W] = c.src;
        w[EN_BIT]           = c.en;
        return w;
    endfunction
endpackage

// File: rtl/clkcfg_decode.sv
module clkcfg_decode
    import clkcfg_pkg::*;
#(
    parameter int                NUM_CH     = 5,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h30
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              sel_load,
    output logic [ID_W-1:0]   sel_id,
    output logic [NUM_CH-1:0] commit,
    output ch_cfg_t           cfg_new
);
    localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_CH);

    logic hit;
    logic id_ok;
    logic is_cmd;
    logic unused_wbits;

    assign hit          = bus_wr && (bus_addr == REG_OFFSET);
    assign sel_id       = bus_wdata[ID_LSB +: ID_W];
    assign id_ok        = ({1'b0, sel_id} < ID_LIMIT);
    assign is_cmd       = bus_wdata[CMD_BIT];
    assign sel_load     = hit && id_ok;
    assign cfg_new      = unpack_cfg(bus_wdata);
    assign unused_wbits = ^{bus_wdata[31:29], bus_wdata[27:21],
                            bus_wdata[15:11], bus_wdata[6:4]};

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            commit[i] = sel_load && is_cmd && (sel_id == ID_W'(i));
        end
    end
endmodule

// File: rtl/clkcfg_chan.sv
module clkcfg_chan
    import clkcfg_pkg::*;
#(
    parameter int   SETTLE_CYC = 4,
    parameter logic RESET_EN   = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    commit,
    input  ch_cfg_t cfg_new,
    output ch_cfg_t cfg,
    output logic    ready
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.en     <= RESET_EN;
            cfg.src    <= '0;
            cfg.div    <= '0;
            settle_cnt <= '0;
        end else if (commit) begin
            cfg        <= cfg_new;
            settle_cnt <= CNT_LOAD;
        end else if (settle_cnt != '0) begin
            settle_cnt <= settle_cnt - 1'b1;
        end
    end

    assign ready = (settle_cnt == '0);
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int                NUM_CH     = 5,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h30,
    parameter int                SETTLE_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [NUM_CH*SRC_W-1:0] ch_src,
    output logic [NUM_CH*DIV_W-1:0] ch_div,
    output logic [NUM_CH-1:0]       ch_en,
    output logic [NUM_CH-1:0]       ch_ready,
    output logic                    rdy_main,
    output logic                    rdy_aux
);
    logic              sel_load;
    logic [ID_W-1:0]   sel_id;
    logic [NUM_CH-1:0] commit;
    ch_cfg_t           cfg_new;
    ch_cfg_t           cfg_arr [NUM_CH];
    logic [ID_W-1:0]   rd_sel;
    ch_cfg_t           rd_cfg;

    clkcfg_decode #(
        .NUM_CH    (NUM_CH),
        .ADDR_W    (ADDR_W),
        .REG_OFFSET(REG_OFFSET)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .sel_load (sel_load),
        .sel_id   (sel_id),
        .commit   (commit),
        .cfg_new  (cfg_new)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        clkcfg_chan #(
            .SETTLE_CYC(SETTLE_CYC),
            .RESET_EN  ((g == 0) ? 1'b1 : 1'b0)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .commit (commit[g]),
            .cfg_new(cfg_new),
            .cfg    (cfg_arr[g]),
            .ready  (ch_ready[g])
        );
        assign ch_src[g*SRC_W +: SRC_W] = cfg_arr[g].src;
        assign ch_div[g*DIV_W +: DIV_W] = cfg_arr[g].div;
        assign ch_en[g]                 = cfg_arr[g].en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sel <= '0;
        end else if (sel_load) begin
            rd_sel <= sel_id;
        end
    end

    always_comb begin
        rd_cfg = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_sel == ID_W'(i)) begin
                rd_cfg = cfg_arr[i];
            end
        end
    end

    assign bus_rdata = (bus_addr == REG_OFFSET) ? pack_word(rd_sel, rd_cfg) : '0;
    assign rdy_main  = ch_ready[0];
    assign rdy_aux   = &ch_ready[NUM_CH-1:1];
endmodule

// File: rtl/clkcfg_regbank_chk.sv
module clkcfg_regbank_chk
    import clkcfg_pkg::*;
#(
    parameter int                NUM_CH     = 5,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h30
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_wr,
    input logic [WORD_W-1:0]       bus_wdata,
    input logic [WORD_W-1:0]       bus_rdata,
    input logic [NUM_CH*SRC_W-1:0] ch_src,
    input logic [NUM_CH*DIV_W-1:0] ch_div,
    input logic [NUM_CH-1:0]       ch_en,
    input logic                    rdy_main,
    input logic                    rdy_aux
);
    logic at_reg;
    logic bad_id;
    assign at_reg = bus_wr && (bus_addr == REG_OFFSET);
    assign bad_id = (bus_wdata[ID_LSB +: ID_W] >= ID_W'(NUM_CH));

    a_r3_nocmd_hold: assert property (@(posedge clk) disable iff (rst)
        (at_reg && !bus_wdata[CMD_BIT]) |=> ($stable(ch_src) && $stable(ch_div) && $stable(ch_en)));

    a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rdata[CMD_BIT]);

    a_r5_bad_id_ignored: assert property (@(posedge clk) disable iff (rst)
        (at_reg && bad_id) |=> ($stable(ch_src) && $stable(ch_div) && $stable(ch_en)));

    a_r6_other_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != REG_OFFSET) |=> ($stable(ch_src) && $stable(ch_div) && $stable(ch_en)));

    a_r7_main_settles: assert property (@(posedge clk) disable iff (rst)
        (at_reg && bus_wdata[CMD_BIT] && bus_wdata[ID_LSB +: ID_W] == '0) |=> !rdy_main);

    a_r8_aux_settles: assert property (@(posedge clk) disable iff (rst)
        (at_reg && bus_wdata[CMD_BIT] && !bad_id && bus_wdata[ID_LSB +: ID_W] != '0) |=> !rdy_aux);
endmodule

bind clkcfg_regbank clkcfg_regbank_chk #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ch_src   (ch_src),
    .ch_div   (ch_div),
    .ch_en    (ch_en),
    .rdy_main (rdy_main),
    .rdy_aux  (rdy_aux)
);

// File: tb/clkcfg_regbank_tb.sv
module clkcfg_regbank_tb;
    localparam int NCH    = 5;
    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [24:0] ch_src;
    logic [14:0] ch_div;
    logic [4:0]  ch_en;
    logic [4:0]  ch_ready;
    logic        rdy_main;
    logic        rdy_aux;

    int errors = 0;
    int checks = 0;

    int m_src [NCH];
    int m_div [NCH];
    int m_en  [NCH];
    int m_sel;

    always #2 clk = ~clk;

    clkcfg_regbank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_src(ch_src),
        .ch_div(ch_div), .ch_en(ch_en), .ch_ready(ch_ready),
        .rdy_main(rdy_main), .rdy_aux(rdy_aux)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_word(input int id);
        return (m_en[id] << 28) | (m_src[id] << 16) | (m_div[id] << 8) | id;
    endfunction

    task automatic check_outputs(input string req);
        for (int c = 0; c < NCH; c++) begin
            chk(req, int'(ch_src[c*5 +: 5]), m_src[c]);
            chk(req, int'(ch_div[c*3 +: 3]), m_div[c]);
            chk(req, int'(ch_en[c]), m_en[c]);
        end
    endtask

    task automatic check_read(input string req);
        bus_addr = 8'h30;
        #1;
        chk(req, int'(bus_rdata), exp_word(m_sel));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 8'h30;
    endtask

    task automatic settle;
        for (int i = 0; i < SETTLE + 1; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input int id, input int cmd, input int src,
                                       input int dv, input int en);
        return 32'((en << 28) | (src << 16) | (dv << 8) | (cmd << 7) | id);
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = 8'h30; bus_wr = 1'b0; bus_wdata = '0;
        for (int c = 0; c < NCH; c++) begin
            m_src[c] = 0; m_div[c] = 0; m_en[c] = (c == 0) ? 1 : 0;
        end
        m_sel = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_outputs("R1");
        chk("R1", int'(ch_ready), 5'h1f);
        check_read("R1");
        chk("R1", int'(bus_rdata), 32'h1000_0000);

        // R2 R9 R7: command writes, several patterns per channel
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < NCH; c++) begin
                int s, d, e;
                s = (c * 7 + p * 11 + 3) % 32;
                d = (c + p * 3 + 1) % 8;
                e = (c + p) % 2;
                if (p == 3) begin s = 31; d = 7; e = 1; end
                wr(8'h30, mk(c, 1, s, d, e) | 32'hE0E0_F870);
                m_src[c] = s; m_div[c] = d; m_en[c] = e; m_sel = c;
                check_outputs("R2");
                // R7 ready low from the first cycle after the write edge
                for (int k = 0; k < SETTLE; k++) begin
                    for (int o = 0; o < NCH; o++)
                        chk("R7", int'(ch_ready[o]), (o == c) ? 0 : 1);
                    chk("R8", int'(rdy_main), (c == 0) ? 0 : 1);
                    chk("R8", int'(rdy_aux), (c == 0) ? 1 : 0);
                    check_read("R9");
                    @(negedge clk);
                end
                chk("R7", int'(ch_ready), 5'h1f);
                chk("R8", int'(rdy_main & rdy_aux), 1);
            end
        end

        // R3 R4: selection-only writes with junk fields, readback of every channel
        for (int c = 0; c < NCH; c++) begin
            wr(8'h30, mk(c, 0, 21, 5, 1) | 32'hE0E0_F870);
            m_sel = c;
            check_outputs("R3");
            chk("R3", int'(ch_ready), 5'h1f);
            check_read("R4");
            chk("R4", int'(bus_rdata[7]), 0);
            bus_addr = 8'h34;
            #1;
            chk("R4", int'(bus_rdata), 0);
        end

        // R5: IDs 5..15 ignored with either command value
        wr(8'h30, mk(2, 0, 0, 0, 0));
        m_sel = 2;
        for (int id = 5; id < 16; id++) begin
            for (int cmd = 0; cmd < 2; cmd++) begin
                wr(8'h30, mk(id, cmd, 9, 2, 1));
                check_outputs("R5");
                chk("R5", int'(ch_ready), 5'h1f);
                check_read("R5");
            end
        end

        // R6: other addresses ignored
        for (int a = 0; a < 256; a += 4) begin
            if (a != 8'h30) begin
                wr(8'(a), mk(a % 5, 1, 17, 6, 0));
                check_outputs("R6");
                chk("R6", int'(ch_ready), 5'h1f);
            end
        end
        check_read("R6");

        // R7: back-to-back commit restarts the settle window
        wr(8'h30, mk(3, 1, 4, 4, 1));
        m_src[3] = 4; m_div[3] = 4; m_en[3] = 1; m_sel = 3;
        @(negedge clk);
        wr(8'h30, mk(3, 1, 5, 5, 0));
        m_src[3] = 5; m_div[3] = 5; m_en[3] = 0;
        check_outputs("R2");
        for (int k = 0; k < SETTLE; k++) begin
            chk("R7", int'(ch_ready[3]), 0);
            @(negedge clk);
        end
        chk("R7", int'(ch_ready[3]), 1);
        check_read("R9");

        settle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule